// File: doc/BRIEF.md
# Audio Capture Sample Packer

The block sits between a set of audio sample sources and a memory writer. A source-select input picks one of several 32-bit sample lanes. From each accepted lane value the block cuts out a bit field bounded by a programmable top and bottom bit position. It then widens the field into an 8, 16 or 32-bit slot, filling the upper bits with copies of the field's top bit or with zeros. Completed 64-bit words pass through a small buffer and leave on a valid/ready write port, together with a byte address. The address walks a ring between a programmed first word address and a programmed last word address.

Software sets up the block while capture is off. It then raises the enable and streams samples. Capture can be made to realign on a first-channel marker, so that channel 0 always opens a word. A burst-ready flag tells a downstream mover when enough words are waiting. A low-high-low pulse on the rewind control sends the next write back to the start of the ring.

Top module: `cap_packer`

## Requirements
- R1: The format code sets the slot size: code 0 gives eight 8-bit slots per word, code 2 gives four 16-bit slots and code 4 gives two 32-bit slots. Slot k occupies word bits [k*S+S-1 : k*S] for slot size S. Samples fill the slots from slot 0 upward in arrival order, and a word is emitted once its top slot is filled.
- R2: With any other format code (1, 3, 5, 6, 7), samples are not taken and no word is written.
- R3: The sample is the field between the top position cfg_msb and the bottom position cfg_lsb, inclusive, of the selected 32-bit lane. It is shifted down so that bit cfg_lsb lands in slot bit 0. Field bits beyond the slot size are dropped.
- R4: With cfg_sign_ext at 1, slot bits above the field copy the field's top bit. With cfg_sign_ext at 0, they are zero.
- R5: Only the lane picked by cfg_src_sel (index 0 to NSRC-1) is used. The valid, marker and data inputs of every other lane have no effect on the written words.
- R6: With cfg_chan_sync at 1, a sample carrying the first-channel marker always goes to slot 0 of a new word, and any partly filled word is dropped. With cfg_chan_sync at 0, the marker has no effect.
- R7: The first word after reset is written at cfg_base_addr. Each accepted write advances the address by 8. After a write at cfg_end_addr, the next address is cfg_base_addr again. The address and data are held while wr_ready is low.
- R8: A rising edge on cfg_force_finish returns the next write address to cfg_base_addr.
- R9: Lowering cfg_enable drops a partly filled word. Capture resumes at slot 0.
- R10: burst_ready is 1 exactly when cfg_threshold is non-zero and the number of words held in the block (buffered or presented, not yet accepted) is at least cfg_threshold. The flag follows the held count and the threshold one cycle later.
- R11: The block holds at most DEPTH+1 words. A word completed while DEPTH+1 words are held is discarded. Held words leave in order.
- R12: After reset, wr_valid and burst_ready are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | NSRC | Sample present, one bit per source |
| src_first | input | NSRC | First-channel marker, one bit per source |
| src_data | input | NSRC*32 | Lane data, source s at bits [32s+31:32s] |
| cfg_enable | input | 1 | Capture enable |
| cfg_src_sel | input | SEL_W | Source index |
| cfg_type | input | 3 | Format code (0, 2, 4 valid) |
| cfg_msb | input | 5 | Field top bit position |
| cfg_lsb | input | 5 | Field bottom bit position |
| cfg_sign_ext | input | 1 | 1: sign-extend, 0: zero-extend |
| cfg_chan_sync | input | 1 | Realign on first-channel marker |
| cfg_force_finish | input | 1 | Rising edge rewinds the write address |
| cfg_base_addr | input | AW | First word address of the ring |
| cfg_end_addr | input | AW | Last word address of the ring |
| cfg_threshold | input | THR_W | Held-word count for burst_ready |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 64 | Packed word |
| burst_ready | output | 1 | Enough words held |

## Verification
Each valid format code is run with random lane data and random field bounds, with signed and unsigned extension. The same data then yields different slot layouts, so wrong slot placement, shifting, truncation or extension shows up as a mismatched word. Fixed samples with a set or clear field top bit separate sign extension from zero extension. A stream that places the first-channel marker mid-word is replayed with realignment on and off to tell the two behaviours apart. Stalled-writer runs fill the buffer to its threshold and its capacity, and long runs wrap the address ring several times.

// File: rtl/cap_pack_pkg.sv
package cap_pack_pkg;
  localparam int LANE_W = 32;

  typedef enum logic [2:0] {
    FMT_B8  = 3'd0,
    FMT_H16 = 3'd2,
    FMT_W32 = 3'd4
  } fmt_e;

  typedef struct packed {
    logic              valid;
    logic              first;
    logic [LANE_W-1:0] val;
  } samp_t;

  function automatic logic fmt_ok(input logic [2:0] code);
    return (code == FMT_B8) || (code == FMT_H16) || (code == FMT_W32);
  endfunction

  // log2 of bytes per slot
  function automatic logic [1:0] fmt_lg(input logic [2:0] code);
    case (code)
      FMT_H16: return 2'd1;
      FMT_W32: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/cap_field_extract.sv
module cap_field_extract #(
  parameter int LW = 32,
  parameter int PW = $clog2(LW)
) (
  input  logic [LW-1:0] raw,
  input  logic [PW-1:0] msb,
  input  logic [PW-1:0] lsb,
  input  logic          sx,
  output logic [LW-1:0] val
);
  logic [LW-1:0] mask, field, fill;
  logic          neg;

  always_comb begin
    for (int i = 0; i < LW; i++)
      mask[i] = (i <= int'(msb)) && (i >= int'(lsb));
    field = (raw & mask) >> lsb;
    fill  = ~(mask >> lsb);
    neg   = sx && raw[msb] && (msb >= lsb);
    val   = neg ? (field | fill) : field;
  end
endmodule

// File: rtl/cap_slot_packer.sv
module cap_slot_packer
  import cap_pack_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LW     = 32,
  parameter int WB     = WORD_W / 8,
  parameter int IDX_W  = $clog2(WB) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [2:0]        fmt,
  input  logic              sync,
  input  logic              s_valid,
  input  logic              s_first,
  input  logic [LW-1:0]     s_val,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic [IDX_W-1:0]  idx, slot, slots;
  logic [1:0]        lg;
  logic              accept, restart, last_slot;
  logic [WORD_W-1:0] acc, merged;

  always_comb begin
    lg        = fmt_lg(fmt);
    slots     = IDX_W'(WB >> lg);
    accept    = en && fmt_ok(fmt) && s_valid;
    restart   = sync && s_first && (idx != '0);
    slot      = restart ? '0 : idx;
    last_slot = (slot == slots - IDX_W'(1));
    merged    = acc;
    for (int b = 0; b < WB; b++) begin
      if ((b >> lg) == int'(slot))
        merged[b*8 +: 8] = s_val[((b & ((1 << lg) - 1)) * 8) +: 8];
    end
  end

  assign push      = accept && last_slot;
  assign push_word = merged;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idx <= '0;
    end else if (accept) begin
      acc <= merged;
      idx <= last_slot ? '0 : slot + IDX_W'(1);
    end
  end

  // R2: a rejected format code never completes a word
  p_bad_type_r2: assert property (@(posedge clk) disable iff (rst)
    !fmt_ok(fmt) |-> !push);
  // R9: dropping the enable clears the fill position
  p_disable_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (idx == '0));
  // R6: a marked sample under realignment lands in slot 0
  p_sync_slot0_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && sync && s_first) |=> (idx == IDX_W'(1)));
endmodule

// File: rtl/cap_word_fifo.sv
module cap_word_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int LVL_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [LVL_W-1:0] cnt;
  logic             do_wr, load;

  assign do_wr = push && (cnt != LVL_W'(DEPTH));
  assign load  = (!out_valid || pop_ready) && (cnt != '0);
  assign level = cnt + LVL_W'(out_valid);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (do_wr) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
      if (load)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + PTR_W'(1);
      cnt <= cnt + LVL_W'(do_wr) - LVL_W'(load);
      if (load)           out_valid <= 1'b1;
      else if (pop_ready) out_valid <= 1'b0;
    end
  end

  // R11: the buffer count never passes its depth
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= LVL_W'(DEPTH));
  // R7: a stalled word stays presented unchanged
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/cap_addr_ring.sv
module cap_addr_ring #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  input  logic          rewind,
  input  logic          fire,
  output logic [AW-1:0] addr
);
  logic rewind_q, rewind_rise;

  assign rewind_rise = rewind && !rewind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rewind_q <= 1'b0;
      addr     <= base;
    end else begin
      rewind_q <= rewind;
      if (rewind_rise)
        addr <= base;
      else if (fire)
        addr <= (addr == last) ? base : addr + AW'(STEP);
    end
  end

  // R8: a rewind edge returns the pointer to the ring start
  p_rewind_r8: assert property (@(posedge clk) disable iff (rst)
    rewind_rise |=> (addr == $past(base)));
  // R7: without a handshake or rewind the pointer holds
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!fire && !rewind_rise) |=> $stable(addr));
endmodule

// File: rtl/cap_packer.sv
module cap_packer
  import cap_pack_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int SEL_W  = $clog2(NSRC),
  parameter int WORD_W = 64,
  parameter int AW     = 32,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        src_valid,
  input  logic [NSRC-1:0]        src_first,
  input  logic [NSRC*LANE_W-1:0] src_data,
  input  logic                   cfg_enable,
  input  logic [SEL_W-1:0]       cfg_src_sel,
  input  logic [2:0]             cfg_type,
  input  logic [4:0]             cfg_msb,
  input  logic [4:0]             cfg_lsb,
  input  logic                   cfg_sign_ext,
  input  logic                   cfg_chan_sync,
  input  logic                   cfg_force_finish,
  input  logic [AW-1:0]          cfg_base_addr,
  input  logic [AW-1:0]          cfg_end_addr,
  input  logic [THR_W-1:0]       cfg_threshold,
  output logic                   wr_valid,
  input  logic                   wr_ready,
  output logic [AW-1:0]          wr_addr,
  output logic [WORD_W-1:0]      wr_data,
  output logic                   burst_ready
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LVL_W      = $clog2(DEPTH + 2);

  logic [LANE_W-1:0] lane_raw, lane_ext;
  logic              lane_v, lane_f;
  samp_t             smp;
  logic              push;
  logic [WORD_W-1:0] push_word;
  logic [LVL_W-1:0]  level;
  logic              fire;

  // lane selection
  always_comb begin
    lane_v   = 1'b0;
    lane_f   = 1'b0;
    lane_raw = '0;
    if (int'(cfg_src_sel) < NSRC) begin
      lane_v   = src_valid[cfg_src_sel];
      lane_f   = src_first[cfg_src_sel];
      lane_raw = src_data[int'(cfg_src_sel)*LANE_W +: LANE_W];
    end
  end

  cap_field_extract #(.LW(LANE_W), .PW(5)) u_extract (
    .raw (lane_raw),
    .msb (cfg_msb),
    .lsb (cfg_lsb),
    .sx  (cfg_sign_ext),
    .val (lane_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      smp <= '0;
    end else begin
      smp.valid <= lane_v && cfg_enable;
      smp.first <= lane_f;
      smp.val   <= lane_ext;
    end
  end

  cap_slot_packer #(.WORD_W(WORD_W), .LW(LANE_W)) u_packer (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_enable),
    .fmt       (cfg_type),
    .sync      (cfg_chan_sync),
    .s_valid   (smp.valid),
    .s_first   (smp.first),
    .s_val     (smp.val),
    .push      (push),
    .push_word (push_word)
  );

  cap_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_word),
    .pop_ready (wr_ready),
    .out_valid (wr_valid),
    .out_data  (wr_data),
    .level     (level)
  );

  assign fire = wr_valid && wr_ready;

  cap_addr_ring #(.AW(AW), .STEP(WORD_BYTES)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .base   (cfg_base_addr),
    .last   (cfg_end_addr),
    .rewind (cfg_force_finish),
    .fire   (fire),
    .addr   (wr_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)
      burst_ready <= 1'b0;
    else
      burst_ready <= (cfg_threshold != '0) &&
                     ({{THR_W{1'b0}}, level} >= {{LVL_W{1'b0}}, cfg_threshold});
  end

  // R10: the flag never rises against a zero threshold
  p_burst_thr_r10: assert property (@(posedge clk) disable iff (rst)
    burst_ready |-> ($past(cfg_threshold) != '0));
endmodule

// File: tb/tb_cap_packer.sv
module tb_cap_packer;
  localparam int NSRC = 8;
  localparam int DEPTH = 16;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] LAST = 32'h0000_1028;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src_valid = '0, src_first = '0;
  logic [NSRC*32-1:0] src_data = '0;
  logic cfg_enable = 1'b0;
  logic [2:0] cfg_src_sel = '0;
  logic [2:0] cfg_type = 3'd4;
  logic [4:0] cfg_msb = 5'd31, cfg_lsb = 5'd0;
  logic cfg_sign_ext = 1'b0, cfg_chan_sync = 1'b0, cfg_force_finish = 1'b0;
  logic [31:0] cfg_base_addr = BASE, cfg_end_addr = LAST;
  logic [7:0] cfg_threshold = '0;
  logic wr_valid, wr_ready = 1'b1, burst_ready;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;

  cap_packer dut (
    .clk(clk), .rst(rst), .src_valid(src_valid), .src_first(src_first),
    .src_data(src_data), .cfg_enable(cfg_enable), .cfg_src_sel(cfg_src_sel),
    .cfg_type(cfg_type), .cfg_msb(cfg_msb), .cfg_lsb(cfg_lsb),
    .cfg_sign_ext(cfg_sign_ext), .cfg_chan_sync(cfg_chan_sync),
    .cfg_force_finish(cfg_force_finish), .cfg_base_addr(cfg_base_addr),
    .cfg_end_addr(cfg_end_addr), .cfg_threshold(cfg_threshold),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .burst_ready(burst_ready)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit rnd_ready = 1'b0;
  logic [63:0] got_d[$], exp_d[$];
  logic [31:0] got_a[$];
  int m_idx = 0;
  logic [63:0] m_acc = '0;
  logic [31:0] m_addr = BASE;

  always @(negedge clk)
    if (!rst && wr_valid && wr_ready) begin
      got_d.push_back(wr_data);
      got_a.push_back(wr_addr);
    end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    if (rnd_ready) wr_ready = ($urandom % 4) != 0;
  endtask

  task automatic idle(input int n);
    src_valid = '0;
    repeat (n) tick();
  endtask

  function automatic logic [31:0] ref_field(input logic [31:0] d, input int msb, input int lsb, input bit sx);
    int w;
    logic [63:0] v, m;
    w = msb - lsb + 1;
    m = (64'd1 << w) - 64'd1;
    v = ({32'd0, d} >> lsb) & m;
    if (sx && v[w-1]) v = v | ~m;
    return v[31:0];
  endfunction

  // model of one taken sample, from R1, R3, R4, R6
  task automatic model_take(input logic [31:0] d, input bit f);
    int sw;
    logic [31:0] e;
    if (!(cfg_type == 3'd0 || cfg_type == 3'd2 || cfg_type == 3'd4)) return;
    sw = (cfg_type == 3'd0) ? 8 : (cfg_type == 3'd2) ? 16 : 32;
    e = ref_field(d, int'(cfg_msb), int'(cfg_lsb), cfg_sign_ext);
    if (cfg_chan_sync && f && m_idx != 0) m_idx = 0;
    for (int b = 0; b < sw; b++) m_acc[m_idx*sw + b] = e[b];
    m_idx++;
    if (m_idx == 64 / sw) begin
      exp_d.push_back(m_acc);
      m_idx = 0;
    end
  endtask

  task automatic send(input logic [31:0] d, input bit f);
    for (int s = 0; s < NSRC; s++) begin
      if (s == int'(cfg_src_sel)) begin
        src_valid[s] = 1'b1;
        src_first[s] = f;
        src_data[s*32 +: 32] = d;
      end else begin
        src_valid[s] = 1'($urandom % 2);
        src_first[s] = 1'($urandom % 2);
        src_data[s*32 +: 32] = $urandom;
      end
    end
    model_take(d, f);
    tick();
  endtask

  task automatic cfg_off();
    idle(2);
    cfg_enable = 1'b0;
    m_idx = 0;
    idle(2);
  endtask

  task automatic cfg_on(input logic [2:0] t, input int msb, input int lsb, input bit sx, input bit sy);
    cfg_type = t; cfg_msb = 5'(msb); cfg_lsb = 5'(lsb);
    cfg_sign_ext = sx; cfg_chan_sync = sy;
    idle(1);
    cfg_enable = 1'b1;
    idle(1);
  endtask

  task automatic drain();
    wr_ready = 1'b1;
    idle(4);
    for (int k = 0; k < 3000 && got_d.size() < exp_d.size(); k++) tick();
    idle(4);
  endtask

  task automatic check_words(input string tag);
    int n;
    chk(got_d.size() == exp_d.size(), {tag, " word count"}, 64'(got_d.size()), 64'(exp_d.size()));
    n = (got_d.size() < exp_d.size()) ? got_d.size() : exp_d.size();
    for (int i = 0; i < n; i++) begin
      chk(got_d[i] == exp_d[i], {tag, " word data"}, got_d[i], exp_d[i]);
      chk(got_a[i] == m_addr, "R7 word address", 64'(got_a[i]), 64'(m_addr));
      m_addr = (m_addr == LAST) ? BASE : m_addr + 32'd8;
    end
    got_d.delete(); got_a.delete(); exp_d.delete();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (4) tick();
    rst = 1'b0;
    idle(2);
    chk(wr_valid == 1'b0, "R12 wr_valid after reset", 64'(wr_valid), 0);
    chk(burst_ready == 1'b0, "R12 burst_ready after reset", 64'(burst_ready), 0);

    // R1: each format with random data
    cfg_on(3'd0, 31, 24, 0, 0);
    for (int i = 0; i < 16; i++) send($urandom, 0);
    cfg_off();
    cfg_on(3'd2, 31, 16, 1, 0);
    for (int i = 0; i < 8; i++) send($urandom, 0);
    cfg_off();
    cfg_on(3'd4, 31, 0, 0, 0);
    for (int i = 0; i < 6; i++) send($urandom, 0);
    cfg_off();
    drain();
    check_words("R1 formats");

    // R3 R4: directed field and extension
    cfg_on(3'd4, 23, 8, 1, 0);
    send(32'h0080_0100, 0);
    send(32'h007F_FF00, 0);
    cfg_off();
    drain();
    chk(got_d.size() == 1 && got_d[0] == 64'h0000_7FFF_FFFF_8001, "R4 signed word",
        (got_d.size() > 0) ? got_d[0] : 64'hx, 64'h0000_7FFF_FFFF_8001);
    check_words("R4 signed");
    cfg_on(3'd4, 23, 8, 0, 0);
    send(32'h0080_0100, 0);
    send(32'h00FF_FF00, 0);
    cfg_off();
    drain();
    chk(got_d.size() == 1 && got_d[0] == 64'h0000_FFFF_0000_8001, "R4 unsigned word",
        (got_d.size() > 0) ? got_d[0] : 64'hx, 64'h0000_FFFF_0000_8001);
    check_words("R4 unsigned");
    cfg_on(3'd0, 23, 8, 1, 0);
    for (int i = 0; i < 8; i++) send(32'h00AB_CD00 + 32'(i << 8), 0);
    cfg_off();
    drain();
    check_words("R3 truncation");

    // R5: other lanes busy
    cfg_src_sel = 3'd5;
    cfg_on(3'd2, 31, 16, 0, 0);
    for (int i = 0; i < 8; i++) send($urandom, 0);
    cfg_off();
    drain();
    check_words("R5 lane select");

    // R6: marker mid-word, realignment on then off
    for (int sy = 1; sy >= 0; sy--) begin
      cfg_on(3'd2, 31, 16, 0, 1'(sy));
      send(32'h1111_0000, 0); send(32'h2222_0000, 0);
      send(32'hAAAA_0000, 1); send(32'hBBBB_0000, 0);
      send(32'hCCCC_0000, 0); send(32'hDDDD_0000, 0);
      cfg_off();
      drain();
      if (sy == 1)
        chk(got_d.size() == 1 && got_d[0] == 64'hDDDD_CCCC_BBBB_AAAA, "R6 realigned word",
            (got_d.size() > 0) ? got_d[0] : 64'hx, 64'hDDDD_CCCC_BBBB_AAAA);
      else
        chk(got_d.size() == 1 && got_d[0] == 64'hBBBB_AAAA_2222_1111, "R6 marker ignored",
            (got_d.size() > 0) ? got_d[0] : 64'hx, 64'hBBBB_AAAA_2222_1111);
      check_words("R6 sync");
    end

    // R9: partial word dropped on disable
    cfg_on(3'd0, 31, 24, 0, 0);
    for (int i = 0; i < 3; i++) send($urandom, 0);
    cfg_off();
    cfg_on(3'd0, 31, 24, 0, 0);
    for (int i = 0; i < 8; i++) send(32'(i + 1) << 24, 0);
    cfg_off();
    drain();
    chk(got_d.size() == 1 && got_d[0] == 64'h0807_0605_0403_0201, "R9 fresh word",
        (got_d.size() > 0) ? got_d[0] : 64'hx, 64'h0807_0605_0403_0201);
    check_words("R9 disable");

    // R2: rejected codes
    for (int c = 3; c <= 7; c += 4) begin
      cfg_on(3'(c), 31, 0, 0, 0);
      for (int i = 0; i < 16; i++) send($urandom, 0);
      cfg_off();
      idle(4);
      chk(got_d.size() == 0 && wr_valid == 1'b0, "R2 no write", 64'(got_d.size()), 0);
    end

    // R10: threshold
    wr_ready = 1'b0;
    cfg_threshold = 8'd3;
    cfg_on(3'd4, 31, 0, 0, 0);
    for (int i = 0; i < 4; i++) send($urandom, 0);
    idle(4);
    chk(burst_ready == 1'b0, "R10 below threshold", 64'(burst_ready), 0);
    for (int i = 0; i < 2; i++) send($urandom, 0);
    idle(4);
    chk(burst_ready == 1'b1, "R10 at threshold", 64'(burst_ready), 1);
    cfg_threshold = 8'd0;
    idle(2);
    chk(burst_ready == 1'b0, "R10 zero threshold", 64'(burst_ready), 0);
    cfg_off();
    drain();
    check_words("R10 words");

    // R11: capacity DEPTH+1
    wr_ready = 1'b0;
    cfg_threshold = 8'(DEPTH + 1);
    cfg_on(3'd4, 31, 0, 0, 0);
    for (int i = 0; i < 40; i++) send($urandom, 0);
    cfg_off();
    idle(2);
    chk(burst_ready == 1'b1, "R11 full level", 64'(burst_ready), 1);
    cfg_threshold = 8'(DEPTH + 2);
    idle(2);
    chk(burst_ready == 1'b0, "R11 level capped", 64'(burst_ready), 0);
    cfg_threshold = 8'd0;
    repeat (3) void'(exp_d.pop_back());
    drain();
    check_words("R11 overflow");

    // R8: rewind pulse
    cfg_force_finish = 1'b0; idle(1);
    cfg_force_finish = 1'b1; idle(1);
    cfg_force_finish = 1'b0; idle(1);
    m_addr = BASE;
    cfg_on(3'd4, 31, 0, 0, 0);
    for (int i = 0; i < 8; i++) send($urandom, 0);
    cfg_off();
    drain();
    check_words("R8 rewind");

    // random segments, R1 R3 R4 R5 R6 R7
    rnd_ready = 1'b1;
    for (int sg = 0; sg < 30; sg++) begin
      int lsb, msb, len;
      logic [2:0] t;
      t = (sg % 3 == 0) ? 3'd0 : (sg % 3 == 1) ? 3'd2 : 3'd4;
      lsb = $urandom % 32;
      msb = lsb + ($urandom % (32 - lsb));
      len = $urandom % 41;
      cfg_src_sel = 3'($urandom % NSRC);
      cfg_on(t, msb, lsb, 1'($urandom % 2), 1'($urandom % 2));
      for (int i = 0; i < len; i++) begin
        send($urandom, ($urandom % 8) == 0);
        if ($urandom % 2) idle(1);
      end
      cfg_off();
    end
    rnd_ready = 1'b0;
    drain();
    check_words("R1 random");

    finish_run();
  end
endmodule